// File: doc/BRIEF.md
# Warm-Boot Header Byte Streamer

This block produces the header that sits in front of a set of FPGA configuration images in flash. The header tells the configuration engine where each image starts. It is made of five records of 32 bytes each. Every record opens with a sync word and then gives a short list of commands: the boot mode, the 24-bit start address of one image, a bank offset and a reboot request. Zero bytes fill the rest of the record.

The records are emitted in slot order. Slot 0 is the image loaded at power-up. Slots 1 to 4 are the four images that a warm boot can select, numbered 00, 01, 10 and 11.

A controller loads up to five start addresses and a count of how many of them are valid, then pulses `start`. The block then sends the 160 header bytes, one per accepted handshake, on a valid/ready byte stream. It marks the final byte with `hdr_last`. Any slot beyond the valid count reuses the address of slot 0.

Top module: `mboot_hdr_stream`

## Requirements
- R1: After reset, `hdr_valid` and `hdr_last` are low. They stay low until `start` is seen.
- R2: Every record begins with the sync bytes 7E AA 99 7E at positions 0 to 3. The command bytes follow at fixed positions:
  - boot mode 92 00 00 at positions 4 to 6 (the final 00 selects warm boot);
  - address command 44 03 at positions 7 and 8;
  - bank offset 82 00 00 at positions 12 to 14;
  - reboot 01 08 at positions 15 and 16.
  For every command other than the sync word, the low nibble of the command byte equals the number of bytes that follow it.
- R3: The 24-bit start address of a record fills positions 9, 10 and 11, most significant byte first.
- R4: Positions 17 to 31 of every record are zero.
- R5: The stream is five records in slot order. Slot s (0 to 4) carries the address at bits [24*s+23 : 24*s] of `slot_addrs`.
- R6: With a valid count n of 1 to 5, slots n to 4 carry the slot 0 address. A count of 0 acts as 1. A count above 5 acts as 5.
- R7: Exactly 160 bytes are sent per stream. `hdr_last` is high only on byte 159. After byte 159 is accepted, `hdr_valid` falls on the next cycle.
- R8: A byte moves only when `hdr_valid` and `hdr_ready` are both high. While `hdr_valid` is high and `hdr_ready` is low, `hdr_data` and `hdr_last` hold their values.
- R9: `slot_addrs` and `slot_count` are captured on the `start` that begins a stream. Changes to them during the stream have no effect. A `start` that arrives during a stream is ignored.
- R10: When `start` is seen while idle, `hdr_valid` rises on the next cycle and the first byte is 7E.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a stream when idle |
| slot_addrs | input | 120 | Five 24-bit image start addresses; slot 0 in the low bits |
| slot_count | input | 3 | Number of valid addresses |
| hdr_valid | output | 1 | Output byte is valid |
| hdr_ready | input | 1 | Sink accepts the byte |
| hdr_data | output | 8 | Header byte |
| hdr_last | output | 1 | Marks byte 159 |

## Verification
The byte sequence is first checked with the five example addresses 160, 160, 157696, 262144 and 294912 and the sink always ready, which pins down the fixed command layout and the order of the address bytes.

A sweep then runs every count from 0 to 7 with five distinct addresses. This separates correct per-slot selection from fallback to slot 0, and shows how counts of 0 and of 5 or more are clamped.

Streams with an irregular ready pattern show that data and the last flag hold while stalled. Changing the inputs and pulsing `start` mid-stream shows that the captured values are the ones sent.

// File: rtl/mboot_hdr_stream.sv
module mboot_hdr_stream #(
  parameter int SLOTS = 5,
  parameter int REC_BYTES = 32,
  localparam int ADDR_W = 24,
  localparam int CNT_W = $clog2(SLOTS + 1),
  localparam int TOTAL = SLOTS * REC_BYTES,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [SLOTS*ADDR_W-1:0] slot_addrs,
  input  logic [CNT_W-1:0]        slot_count,
  output logic                    hdr_valid,
  input  logic                    hdr_ready,
  output logic [7:0]              hdr_data,
  output logic                    hdr_last
);

  logic [SLOTS*ADDR_W-1:0] addrs_q;
  logic [CNT_W-1:0]        count_q;
  logic [IDX_W-1:0]        idx_q;
  logic                    busy_q;
  logic [ADDR_W-1:0]       cur_addr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      idx_q   <= '0;
      addrs_q <= '0;
      count_q <= '0;
    end else if (!busy_q) begin
      if (start) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        addrs_q <= slot_addrs;
        count_q <= slot_count;
      end
    end else if (hdr_ready) begin
      if (idx_q == IDX_W'(TOTAL - 1)) busy_q <= 1'b0;
      else idx_q <= idx_q + 1'b1;
    end
  end

  always_comb begin
    int slot, pos, used, sel;
    slot = int'(idx_q) / REC_BYTES;
    pos  = int'(idx_q) % REC_BYTES;
    used = int'(count_q);
    if (used < 1) used = 1;
    if (used > SLOTS) used = SLOTS;
    sel = (slot < used) ? slot : 0;
    cur_addr = addrs_q[sel*ADDR_W +: ADDR_W];
    case (pos)
      0, 3:    hdr_data = 8'h7E;
      1:       hdr_data = 8'hAA;
      2:       hdr_data = 8'h99;
      4:       hdr_data = 8'h92;
      7:       hdr_data = 8'h44;
      8:       hdr_data = 8'h03;
      9:       hdr_data = cur_addr[23:16];
      10:      hdr_data = cur_addr[15:8];
      11:      hdr_data = cur_addr[7:0];
      12:      hdr_data = 8'h82;
      15:      hdr_data = 8'h01;
      16:      hdr_data = 8'h08;
      default: hdr_data = 8'h00;
    endcase
  end

  assign hdr_valid = busy_q;
  assign hdr_last  = busy_q && (idx_q == IDX_W'(TOTAL - 1));

endmodule

module mboot_hdr_stream_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       hdr_valid,
  input logic       hdr_ready,
  input logic [7:0] hdr_data,
  input logic       hdr_last
);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && !hdr_ready |=> hdr_valid && $stable(hdr_data) && $stable(hdr_last));

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_last |-> hdr_valid);

  p_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid && hdr_ready && hdr_last |=> !hdr_valid);

  p_launch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    start && !hdr_valid |=> hdr_valid && hdr_data == 8'h7E);

  p_first_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hdr_valid) |-> hdr_data == 8'h7E && !hdr_last);

endmodule

bind mboot_hdr_stream mboot_hdr_stream_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .hdr_valid(hdr_valid),
  .hdr_ready(hdr_ready), .hdr_data(hdr_data), .hdr_last(hdr_last)
);

// File: tb/mboot_hdr_stream_tb.sv
module mboot_hdr_stream_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [119:0] slot_addrs = '0;
  logic [2:0]   slot_count = '0;
  logic         hdr_valid, hdr_ready, hdr_last;
  logic [7:0]   hdr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mboot_hdr_stream dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .slot_addrs(slot_addrs),
    .slot_count(slot_count), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .hdr_last(hdr_last)
  );

  function automatic logic [7:0] exp_byte(input logic [119:0] a, input int cnt, input int i);
    int slot, pos, used;
    logic [23:0] ad;
    slot = i / 32;
    pos  = i % 32;
    used = (cnt < 1) ? 1 : ((cnt > 5) ? 5 : cnt);
    ad = (slot < used) ? a[slot*24 +: 24] : a[23:0];
    case (pos)
      0: return 8'h7E;  1: return 8'hAA;  2: return 8'h99;  3: return 8'h7E;
      4: return 8'h92;  7: return 8'h44;  8: return 8'h03;
      9: return ad[23:16]; 10: return ad[15:8]; 11: return ad[7:0];
      12: return 8'h82; 15: return 8'h01; 16: return 8'h08;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input int i);
    int pos;
    pos = i % 32;
    if (pos == 0 && i > 0) return "R5";
    if (pos < 9 || (pos > 11 && pos < 17)) return "R2";
    if (pos < 12) return "R3";
    return "R4";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // mode 0: always ready; 1: irregular ready; 2: irregular ready plus mid-stream disturbance
  task automatic run_stream(input logic [119:0] a, input int cnt, input int mode, input string rq);
    int idx, cyc;
    bit held;
    logic [7:0] hd;
    logic hl;
    @(negedge clk);
    slot_addrs = a;
    slot_count = 3'(cnt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R10", int'(hdr_valid), 1);
    idx = 0; cyc = 0; held = 0;
    while (idx < 160 && cyc < 2000) begin
      hdr_ready = (mode == 0) ? 1'b1 : (((cyc * 7 + 3) % 5) != 0);
      start = (mode == 2 && (idx == 40 || idx == 41));
      if (mode == 2 && idx == 40) begin
        slot_addrs = ~a;
        slot_count = 3'(5 - cnt % 5);
      end
      if (held) begin
        check("R8", int'({hdr_last, hdr_data}), int'({hl, hd}));
        held = 0;
      end
      if (!hdr_valid) begin
        check("R7", 0, 1);
        break;
      end
      if (hdr_ready) begin
        check(rq.len() > 0 ? rq : tag_of(idx), int'(hdr_data), int'(exp_byte(a, cnt, idx)));
        if (idx == 159 || idx % 32 == 31) check("R7", int'(hdr_last), int'(idx == 159));
        idx++;
      end else begin
        held = 1; hd = hdr_data; hl = hdr_last;
      end
      cyc++;
      @(negedge clk);
    end
    start = 1'b0;
    hdr_ready = 1'b1;
    check("R7", int'(hdr_valid), 0);
    check("R7", idx, 160);
  endtask

  initial begin
    logic [119:0] ex, ds;
    hdr_ready = 1'b1;
    ex = {24'd294912, 24'd262144, 24'd157696, 24'd160, 24'd160};
    ds = {24'hE1D2C3, 24'hA4B5C6, 24'h778899, 24'h102030, 24'h0A0B0C};
    repeat (3) @(negedge clk);
    check("R1", int'({hdr_valid, hdr_last}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({hdr_valid, hdr_last}), 0);
    run_stream(ex, 5, 0, "");
    for (int c = 0; c < 8; c++) run_stream(ds, c, 0, (c < 5) ? "R6" : "");
    run_stream(ds, 3, 1, "R8");
    run_stream(ds, 5, 2, "R9");
    run_stream(ex, 2, 2, "R9");
    repeat (3) @(negedge clk);
    check("R1", int'(hdr_valid), 0);
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule